// File: doc/BRIEF.md
# Channel and Manager Thread Arbiter

This block decides which execution thread a DMA engine's core works on next. A set of channel threads raise requests through a vector, and one manager thread has a request line of its own. The arbiter gives a registered one-hot grant, with a separate flag for the manager. The grant stays in place until the core pulses `accept`. On that pulse the arbiter makes the next decision and grants again on the following clock edge, so there is no idle cycle between services.

The channels share service in a fixed rotation and all have equal rank. Once a channel has been served, the manager gets a turn before any further channel is served, if it is asking for one. When the manager is not asking, its turn is skipped within the same decision. No setting, input or register can change this order.

Top module: `dma_thread_arbiter`

## Requirements
- R1: A grant goes only to a thread whose request was high in the cycle the decision was made. The grant appears on the outputs one clock edge after that cycle.
- R2: At most one of the `NUM_CH` channel grant bits and the manager flag is high at any time. Bit i of `grant_ch` means channel i, and `grant_mgr` high means the manager.
- R3: A grant stays unchanged until `accept` is high at a clock edge, even if its request drops in the meantime. An `accept` while nothing is granted has no effect on grants or on the rotation.
- R4: Channels are served in rotation. After channel i is accepted, the search for the next channel starts at index i+1 and wraps from `NUM_CH`-1 to 0. Channels that are not requesting are skipped in the same decision.
- R5: After a channel grant is accepted, the manager is granted next if `mgr_req` is high at that decision. This happens before any further channel is served.
- R6: If the manager is not requesting when its turn comes, the next requesting channel is granted in that same decision, with no empty cycle.
- R7: When no thread requests at a decision point, no grant is given. The rotation start position is kept unchanged for the next decision.
- R8: Reset is synchronous and active low. It clears all grants, sets the rotation start to channel 0, and makes the manager's turn pending, so a requesting manager is served first after reset.
- R9: An `accept` with requests pending produces the next grant on the very next clock edge.
- R10: If the manager is the only requester, it is granted again after each accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_req | input | NUM_CH | Request from each channel thread |
| mgr_req | input | 1 | Request from the manager thread |
| accept | input | 1 | Core has taken the current grant |
| grant_ch | output | NUM_CH | One-hot channel grant |
| grant_mgr | output | 1 | Manager holds the grant |

## Verification
Completing a channel service and the manager's turn coming due both fall on the same `accept` edge. At that edge the arbiter must choose between the manager and the next channel in the rotation. The bench provokes this by keeping the manager and several channels requesting across back-to-back accepts, and by raising the manager request only after a channel grant is already held. It then checks that the grant alternates between the manager and the channels in the predicted order. It also drops the manager request at the moment its turn arrives and checks that the next channel is granted on the same edge.

// File: rtl/dta_pkg.sv
package dta_pkg;
    // Outcome of one arbitration decision
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_CHAN = 2'd1,
        PICK_MGR  = 2'd2
    } pick_e;
endpackage

// File: rtl/dta_rr_pick.sv
// Rotating-priority search: first set request at or after start, wrapping.
module dta_rr_pick #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  start,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    localparam int CW = IDX_W + 1;

    always_comb begin
        logic [CW-1:0] cand;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            cand = CW'(start) + CW'(k);
            if (cand >= CW'(NUM_CH)) begin
                cand = cand - CW'(NUM_CH);
            end
            if (!found && req[cand[IDX_W-1:0]]) begin
                found = 1'b1;
                idx   = cand[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dta_ptr_step.sv
// Turns a one-hot channel grant into the rotation index just above it.
module dta_ptr_step #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] gnt_oh,
    output logic [IDX_W-1:0]  nxt_idx
);
    logic [IDX_W-1:0] enc;

    always_comb begin
        enc = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (gnt_oh[i]) begin
                enc = enc | IDX_W'(i);
            end
        end
        nxt_idx = (enc == IDX_W'(NUM_CH - 1)) ? '0 : enc + IDX_W'(1);
    end
endmodule

// File: rtl/dma_thread_arbiter.sv
module dma_thread_arbiter #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic              mgr_req,
    input  logic              accept,
    output logic [NUM_CH-1:0] grant_ch,
    output logic              grant_mgr
);
    import dta_pkg::*;

    localparam int IDX_W = $clog2(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0] gnt;   // held channel grant
        logic              mgr;   // manager holds the grant
        logic [IDX_W-1:0]  ptr;   // where the channel search starts
        logic              due;   // manager turn pending
    } arb_st_t;

    arb_st_t s_q, s_d;

    logic             busy;
    logic             take;
    logic [IDX_W-1:0] ptr_adv;
    logic [IDX_W-1:0] ptr_e;
    logic             due_e;
    logic             found;
    logic [IDX_W-1:0] pick_idx;
    pick_e            pick;

    dta_ptr_step #(.NUM_CH(NUM_CH)) u_step (
        .gnt_oh  (s_q.gnt),
        .nxt_idx (ptr_adv)
    );

    dta_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req   (ch_req),
        .start (ptr_e),
        .found (found),
        .idx   (pick_idx)
    );

    always_comb begin
        busy  = (|s_q.gnt) | s_q.mgr;
        take  = busy & accept;
        // State as it stands once the current grant is retired
        ptr_e = (take && !s_q.mgr) ? ptr_adv : s_q.ptr;
        due_e = take ? ~s_q.mgr : s_q.due;

        if (mgr_req && (due_e || !found)) begin
            pick = PICK_MGR;
        end else if (found) begin
            pick = PICK_CHAN;
        end else begin
            pick = PICK_NONE;
        end

        s_d = s_q;
        if (!busy || accept) begin
            s_d.ptr = ptr_e;
            s_d.due = due_e;
            s_d.gnt = '0;
            s_d.mgr = 1'b0;
            case (pick)
                PICK_CHAN: s_d.gnt[pick_idx] = 1'b1;
                PICK_MGR:  s_d.mgr = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{gnt: '0, mgr: 1'b0, ptr: '0, due: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_ch  = s_q.gnt;
    assign grant_mgr = s_q.mgr;

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_mgr, grant_ch}));  // R2

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept) |=> ($stable(grant_ch) && $stable(grant_mgr)));  // R3

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || accept) |=> (((grant_ch & ~$past(ch_req)) == '0)
                               && (!grant_mgr || $past(mgr_req))));  // R1

    AST_MGR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_ch) && accept && mgr_req) |=> grant_mgr);  // R5

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((!busy || accept) && ((|ch_req) || mgr_req)) |=> ((|grant_ch) || grant_mgr));  // R6

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((!busy || accept) && (ch_req == '0) && !mgr_req) |=> ((grant_ch == '0) && !grant_mgr));  // R7
endmodule

// File: tb/dma_thread_arbiter_tb.sv
`timescale 1ns/1ps
module dma_thread_arbiter_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] ch_req;
    logic         mgr_req;
    logic         accept;
    logic [N-1:0] grant_ch;
    logic         grant_mgr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dma_thread_arbiter #(.NUM_CH(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_req    (ch_req),
        .mgr_req   (mgr_req),
        .accept    (accept),
        .grant_ch  (grant_ch),
        .grant_mgr (grant_mgr)
    );

    task automatic chk(input string rq, input logic [N-1:0] exp_ch, input logic exp_m);
        checks++;
        if (grant_ch !== exp_ch || grant_mgr !== exp_m) begin
            errors++;
            $display("FAIL %s grant_ch=%b grant_mgr=%b expected %b %b",
                     rq, grant_ch, grant_mgr, exp_ch, exp_m);
        end
        checks++;
        if ($countones({grant_mgr, grant_ch}) > 1) begin
            errors++;
            $display("FAIL R2 grants=%b expected at most one set", {grant_mgr, grant_ch});
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_accept();
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ch_req = '0; mgr_req = 1'b0; accept = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; ch_req = 8'hFF; mgr_req = 1'b1; accept = 1'b0;
        repeat (3) step();
        chk("R8 grants cleared in reset", 8'h00, 1'b0);
        ch_req = '0; mgr_req = 1'b0; rst_n = 1'b1;
        step();
        chk("R8 idle after reset", 8'h00, 1'b0);
    endtask

    task automatic test_rotation();
        do_reset();
        ch_req = 8'b0100_1010;
        step();
        chk("R1 R6 first channel from pointer 0", 8'h02, 1'b0);
        repeat (3) step();
        chk("R3 grant held without accept", 8'h02, 1'b0);
        ch_req = 8'b0100_1000;
        step();
        chk("R3 grant held after request drops", 8'h02, 1'b0);
        ch_req = 8'b0100_1010;
        pulse_accept();
        chk("R4 next channel 3", 8'h08, 1'b0);
        pulse_accept();
        chk("R4 next channel 6", 8'h40, 1'b0);
        pulse_accept();
        chk("R4 wrap to channel 1", 8'h02, 1'b0);
    endtask

    task automatic test_interleave();
        do_reset();
        ch_req = 8'b0000_0101; mgr_req = 1'b1;
        step();
        chk("R8 manager first after reset", 8'h00, 1'b1);
        pulse_accept();
        chk("R9 channel 0 back to back", 8'h01, 1'b0);
        pulse_accept();
        chk("R5 manager after channel 0", 8'h00, 1'b1);
        pulse_accept();
        chk("R4 channel 2", 8'h04, 1'b0);
        pulse_accept();
        chk("R5 manager after channel 2", 8'h00, 1'b1);
        pulse_accept();
        chk("R4 wrap to channel 0", 8'h01, 1'b0);
    endtask

    task automatic test_idle_ptr();
        do_reset();
        ch_req = 8'h04;
        step();
        chk("R1 channel 2", 8'h04, 1'b0);
        ch_req = '0;
        pulse_accept();
        chk("R7 no grant when idle", 8'h00, 1'b0);
        repeat (4) step();
        chk("R7 still idle", 8'h00, 1'b0);
        ch_req = 8'h22;
        step();
        chk("R7 pointer kept at 3", 8'h20, 1'b0);
    endtask

    task automatic test_accept_ignored();
        do_reset();
        ch_req = 8'h08;
        step();
        chk("R1 channel 3", 8'h08, 1'b0);
        ch_req = '0;
        pulse_accept();
        chk("R7 idle after service", 8'h00, 1'b0);
        pulse_accept();
        chk("R3 accept with no grant", 8'h00, 1'b0);
        pulse_accept();
        ch_req = 8'h09;
        step();
        chk("R3 pointer untouched by stray accept", 8'h01, 1'b0);
    endtask

    task automatic test_skip_wrap();
        do_reset();
        ch_req = 8'h80;
        step();
        chk("R4 skip to channel 7", 8'h80, 1'b0);
        ch_req = 8'h81;
        pulse_accept();
        chk("R4 wrap to channel 0", 8'h01, 1'b0);
        pulse_accept();
        chk("R4 back to channel 7", 8'h80, 1'b0);
    endtask

    task automatic test_mgr_only();
        do_reset();
        mgr_req = 1'b1;
        step();
        chk("R10 manager alone", 8'h00, 1'b1);
        pulse_accept();
        chk("R10 manager again", 8'h00, 1'b1);
        mgr_req = 1'b0;
        pulse_accept();
        chk("R7 nothing left", 8'h00, 1'b0);
    endtask

    task automatic test_mgr_late();
        do_reset();
        ch_req = 8'h03;
        step();
        chk("R6 manager absent, channel 0", 8'h01, 1'b0);
        mgr_req = 1'b1;
        pulse_accept();
        chk("R5 manager before channel 1", 8'h00, 1'b1);
        mgr_req = 1'b0;
        pulse_accept();
        chk("R4 channel 1 after manager", 8'h02, 1'b0);
        pulse_accept();
        chk("R6 turn skipped, channel 0", 8'h01, 1'b0);
    endtask

    initial begin
        test_reset();
        test_rotation();
        test_interleave();
        test_idle_ptr();
        test_accept_ignored();
        test_skip_wrap();
        test_mgr_only();
        test_mgr_late();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule